// File: doc/BRIEF.md
# Parallel Video Scrambler and NRZI Encoder

This block prepares 10-bit parallel video characters for a serial digital video link. It accepts one character per clock and runs it through a self-synchronizing scrambler built on the polynomial x^9 + x^4 + 1. The scrambled bits then go through an NRZ-to-NRZI converter. The result is a 10-bit word that an external serializer shifts out starting at bit 0. All ten bits of a character are handled in one clock. The scrambler and NRZI state carry over from each character to the next, so the output stream is the same as a bit-serial encoder would produce. An 8-bit stream travels on the same 10-bit path.

Each character is first captured in an input register, together with its routing decision, and is then presented from an output register. A multiplexer sits between the two registers and chooses between the encoded word and the raw word. There are two ways to select raw passthrough. One is a bypass request, which is sampled with the data. The other is an active-low raw-mode input. When raw mode is asserted it overrides the bypass request, so the bypass request has no effect. While a character passes through raw, the encoder state stays frozen. Encoding then picks up exactly where it stopped.

Top module: `sdi_scrambler_enc`

## Requirements
- R1: On an encoded character, each scrambled bit s[n] equals d[n] XOR s[n-4] XOR s[n-9], where n counts serial bits and bit 0 of a character is the first serial bit.
- R2: NRZI is applied after scrambling. Each output bit y[n] equals y[n-1] XOR s[n].
- R3: The 9-bit scrambler history and the 1-bit NRZI level carry across consecutive encoded characters. All ten bits advance in one clock.
- R4: When bypass_req is 1 and raw_mode_n is 1 at the capturing edge, char_out presents that character's bits unchanged.
- R5: When raw_mode_n is 0 at the capturing edge, char_out presents the character unchanged, whether bypass_req is 0 or 1. In this case bypass_req has no effect.
- R6: A character on char_in at clock edge k appears on char_out after edge k+1, which is two register stages.
- R7: Synchronous active-high reset clears the scrambler history, the NRZI level and char_out to zero. After reset, encoding starts from that all-zero state.
- R8: Raw characters leave the scrambler history and the NRZI level unchanged. The next encoded character continues from the state left by the last encoded one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| char_in | input | 10 | Parallel character in; bit 0 is the first serial bit |
| bypass_req | input | 1 | 1 selects raw passthrough when raw_mode_n is 1 |
| raw_mode_n | input | 1 | Active-low raw mode; forces passthrough and overrides bypass_req |
| char_out | output | 10 | Registered encoded or raw character for the serializer |

## Verification
The assertions check four things on every clock. A raw character reaches the output one edge after capture with no change. The encoder state is frozen across raw cycles. The last output bit of an encoded word matches the new NRZI level. The newest scrambler history bit matches the NRZI decode of the word's last two bits. The bench's bit-serial reference model is the only check that the full polynomial taps, the bit order and the chaining of state across characters are correct. The model covers long mixed sequences of encoded and raw words, and it is also checked after a reset in the middle of a stream.

// File: rtl/sdi_scr_pkg.sv
package sdi_scr_pkg;

    localparam int CHAR_W   = 10;
    localparam int HIST_LEN = 9;
    localparam int TAP_NEAR = 4;

    typedef enum logic [1:0] {
        PATH_ENCODE  = 2'd0,
        PATH_BYPASS  = 2'd1,
        PATH_RAWMODE = 2'd2
    } path_e;

    function automatic path_e pick_path(input logic bypass, input logic mode_n);
        if (!mode_n)
            return PATH_RAWMODE;
        else if (bypass)
            return PATH_BYPASS;
        return PATH_ENCODE;
    endfunction

    function automatic logic path_is_raw(input path_e p);
        return p != PATH_ENCODE;
    endfunction

endpackage

// File: rtl/sdi_scr_in_stage.sv
module sdi_scr_in_stage
    import sdi_scr_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] char_in,
    input  logic         bypass_req,
    input  logic         raw_mode_n,
    output logic [W-1:0] data_q,
    output path_e        path_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            path_q <= PATH_ENCODE;
        end else begin
            data_q <= char_in;
            path_q <= pick_path(bypass_req, raw_mode_n);
        end
    end

endmodule

// File: rtl/sdi_scr_unroll.sv
module sdi_scr_unroll #(
    parameter int W    = 10,
    parameter int HLEN = 9,
    parameter int TAP  = 4
) (
    input  logic [W-1:0]    data,
    input  logic [HLEN-1:0] hist,
    output logic [W-1:0]    scr,
    output logic [HLEN-1:0] hist_next
);

    localparam int EXT = HLEN + W;

    logic [EXT-1:0] ext;

    always_comb begin
        ext = '0;
        for (int j = 0; j < HLEN; j++)
            ext[HLEN-1-j] = hist[j];
        for (int n = 0; n < W; n++)
            ext[HLEN+n] = data[n] ^ ext[HLEN+n-TAP] ^ ext[n];
        for (int n = 0; n < W; n++)
            scr[n] = ext[HLEN+n];
        for (int j = 0; j < HLEN; j++)
            hist_next[j] = ext[EXT-1-j];
    end

endmodule

// File: rtl/sdi_nrzi_unroll.sv
module sdi_nrzi_unroll #(
    parameter int W = 10
) (
    input  logic [W-1:0] nrz,
    input  logic         level,
    output logic [W-1:0] nrzi,
    output logic         level_next
);

    always_comb begin
        logic run;
        run = level;
        for (int n = 0; n < W; n++) begin
            run     = run ^ nrz[n];
            nrzi[n] = run;
        end
        level_next = run;
    end

endmodule

// File: rtl/sdi_scr_out_stage.sv
module sdi_scr_out_stage
    import sdi_scr_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  path_e        path,
    input  logic [W-1:0] raw_word,
    input  logic [W-1:0] enc_word,
    output logic [W-1:0] word_q
);

    logic [W-1:0] sel_word;

    always_comb begin
        unique case (path)
            PATH_ENCODE:  sel_word = enc_word;
            PATH_BYPASS,
            PATH_RAWMODE: sel_word = raw_word;
            default:      sel_word = raw_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else
            word_q <= sel_word;
    end

endmodule

// File: rtl/sdi_scrambler_enc.sv
module sdi_scrambler_enc
    import sdi_scr_pkg::*;
#(
    parameter int W    = CHAR_W,
    parameter int HLEN = HIST_LEN,
    parameter int TAP  = TAP_NEAR
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] char_in,
    input  logic         bypass_req,
    input  logic         raw_mode_n,
    output logic [W-1:0] char_out
);

    logic [W-1:0]    data_q;
    path_e           path_q;
    logic            raw_q;
    logic [HLEN-1:0] hist_q;
    logic [HLEN-1:0] hist_d;
    logic            level_q;
    logic            level_d;
    logic [W-1:0]    scr_word;
    logic [W-1:0]    enc_word;

    sdi_scr_in_stage #(.W(W)) u_in (
        .clk        (clk),
        .rst        (rst),
        .char_in    (char_in),
        .bypass_req (bypass_req),
        .raw_mode_n (raw_mode_n),
        .data_q     (data_q),
        .path_q     (path_q)
    );

    assign raw_q = path_is_raw(path_q);

    sdi_scr_unroll #(.W(W), .HLEN(HLEN), .TAP(TAP)) u_scr (
        .data      (data_q),
        .hist      (hist_q),
        .scr       (scr_word),
        .hist_next (hist_d)
    );

    sdi_nrzi_unroll #(.W(W)) u_nrzi (
        .nrz        (scr_word),
        .level      (level_q),
        .nrzi       (enc_word),
        .level_next (level_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            level_q <= 1'b0;
        end else if (!raw_q) begin
            hist_q  <= hist_d;
            level_q <= level_d;
        end
    end

    sdi_scr_out_stage #(.W(W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .path     (path_q),
        .raw_word (data_q),
        .enc_word (enc_word),
        .word_q   (char_out)
    );

endmodule

// File: rtl/sdi_scrambler_enc_chk.sv
module sdi_scrambler_enc_chk #(
    parameter int W    = 10,
    parameter int HLEN = 9
) (
    input logic            clk,
    input logic            rst,
    input logic            raw_mode_n,
    input logic            raw_q,
    input logic [W-1:0]    data_q,
    input logic [HLEN-1:0] hist_q,
    input logic            level_q,
    input logic [W-1:0]    char_out
);

    p_raw_pass_r4: assert property (@(posedge clk) disable iff (rst)
        raw_q |=> (char_out == $past(data_q)));

    p_mode_forces_raw_r5: assert property (@(posedge clk) disable iff (rst)
        !raw_mode_n |=> raw_q);

    p_state_hold_r8: assert property (@(posedge clk) disable iff (rst)
        raw_q |=> ($stable(hist_q) && $stable(level_q)));

    p_level_tail_r2: assert property (@(posedge clk) disable iff (rst)
        !raw_q |=> (char_out[W-1] == level_q));

    p_hist_decode_r3: assert property (@(posedge clk) disable iff (rst)
        !raw_q |=> (hist_q[0] == (char_out[W-1] ^ char_out[W-2])));

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hist_q == '0 && !level_q && char_out == '0));

endmodule

bind sdi_scrambler_enc sdi_scrambler_enc_chk #(.W(W), .HLEN(HLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .raw_mode_n (raw_mode_n),
    .raw_q      (raw_q),
    .data_q     (data_q),
    .hist_q     (hist_q),
    .level_q    (level_q),
    .char_out   (char_out)
);

// File: tb/sdi_scrambler_enc_test.sv
module sdi_scrambler_enc_test;

    localparam int W = 10;
    localparam int NV = 22;

    // {raw_mode_n, bypass_req, char_in}
    localparam logic [11:0] VEC [NV] = '{
        12'h800, 12'hBFF, 12'hA00, 12'h801, 12'h955, 12'hAAA,
        12'hD23, 12'hFC0, 12'h8F0, 12'h321, 12'h4AB, 12'hBFC,
        12'h804, 12'h800, 12'h800, 12'h800, 12'h9FF, 12'hC00,
        12'hAD3, 12'hB5A, 12'h0F0, 12'h866
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] char_in = '0;
    logic         bypass_req = 1'b0;
    logic         raw_mode_n = 1'b1;
    logic [W-1:0] char_out;

    int tests = 0;
    int fails = 0;

    logic [8:0]   ref_hist;
    logic         ref_level;
    logic [W-1:0] eh [2];
    string        th [2];
    logic         hv [2];
    logic         last_raw;

    always #10 clk = ~clk;

    sdi_scrambler_enc uut (
        .clk        (clk),
        .rst        (rst),
        .char_in    (char_in),
        .bypass_req (bypass_req),
        .raw_mode_n (raw_mode_n),
        .char_out   (char_out)
    );

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: char_out=%03h expected %03h", tag, act, exp);
        end
    endtask

    // bit-serial reference: scramble then NRZI, bit 0 first
    task automatic model(input logic [11:0] v, output logic [W-1:0] exp);
        logic s;
        if (!v[11] || v[10]) begin
            exp = v[W-1:0];
        end else begin
            for (int n = 0; n < W; n++) begin
                s = v[n] ^ ref_hist[3] ^ ref_hist[8];
                ref_hist = {ref_hist[7:0], s};
                ref_level = ref_level ^ s;
                exp[n] = ref_level;
            end
        end
    endtask

    task automatic step(input logic [11:0] v);
        logic [W-1:0] e;
        string tag;
        @(negedge clk);
        if (hv[1]) check(char_out, eh[1], th[1]);
        eh[1] = eh[0]; th[1] = th[0]; hv[1] = hv[0];
        char_in = v[W-1:0];
        bypass_req = v[10];
        raw_mode_n = v[11];
        if (!v[11]) tag = v[10] ? "R5 raw mode, bypass 1" : "R5 raw mode, bypass 0";
        else if (v[10]) tag = "R4 bypass";
        else if (last_raw) tag = "R8 resume after raw (R1 R2 R6)";
        else tag = "R1 R2 R3 R6 encode";
        last_raw = !v[11] || v[10];
        model(v, e);
        eh[0] = e; th[0] = tag; hv[0] = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        char_in = '0; bypass_req = 1'b0; raw_mode_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(char_out, '0, "R7 output cleared in reset");
        rst = 1'b0;
        ref_hist = '0; ref_level = 1'b0;
        eh[0] = '0; eh[1] = '0;
        th[0] = "R7 idle after reset"; th[1] = "R7 idle after reset";
        hv[0] = 1'b1; hv[1] = 1'b1;
        last_raw = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) step(VEC[i]);
        step(12'h800);
        step(12'h800);

        // R7: reset mid-stream with nonzero state, then encode from zero state
        step(12'h9A5);
        step(12'h837);
        do_reset();
        step(12'h801);
        step(12'hA00);
        step(12'h97E);
        step(12'hC55);
        step(12'h8C3);
        step(12'h800);
        step(12'h800);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule